// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block drives the system clock of a small processor core from one of two sources: an always-running internal RC clock and an external crystal or resonator clock. A crystal needs time to settle, so after power-up or wake-up the block runs the core from the internal clock while a start-up timer counts a fixed number of external clock cycles. Once that count completes, the block moves the system clock over to the external source without producing any runt pulse, and it raises a status bit that software reads to learn which source is active.

A configuration field selects the oscillator mode. Three crystal modes need the start-up count. One mode takes a ready external clock directly. The remaining modes run from the internal clock only. A dual-start enable chooses between running early from the internal clock and holding the system clock low until the count ends. A software select bit forces the internal clock at any time. A sleep request stops the system clock and abandons any count in progress. A wake event starts a fresh two-speed start-up.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: From reset until `pwrup_ok` is first seen high, `sys_clk` stays low and `xtal_active` is 0.
- R2: In a crystal mode (`osc_cfg` 0, 1 or 2) with `dual_start_en`=1 and the software select at 0, `sys_clk` follows the internal clock from power-up until the handover, and `xtal_active` stays 0 during that time.
- R3: The start-up timer counts OST_CYCLES (default 1024) rising edges of `clk_xtal` after counting begins. `xtal_active` rises no earlier than that, and within a few clock cycles after it.
- R4: The handover follows this order. The internal clock is gated off at a falling edge of `clk_rc`, and `xtal_active` rises at that same edge. `sys_clk` then stays low. The external clock is gated on at a falling edge of `clk_xtal`. The two gates are never open together, and `sys_clk` never shows a pulse shorter than half a period of its faster source.
- R5: In a crystal mode with `dual_start_en`=0 and the software select at 0, `sys_clk` is held low until the count completes and then follows `clk_xtal`.
- R6: `osc_cfg`=3 selects the external clock at once, with no count, and sets `xtal_active`. `osc_cfg` 4 to 7 select the internal clock, with `xtal_active` at 0.
- R7: A software select of 1, written with `clksel_we`/`clksel_wdata`, makes `sys_clk` follow `clk_rc` in every mode, with `xtal_active` at 0. Writing it back to 0 returns to the mode's source, without a new count if the count has already completed.
- R8: Reset clears the software select. The automatic handover never changes it; only a write does.
- R9: A `sleep_req` while awake stops `sys_clk` (held low), clears `xtal_active` and clears the start-up count. A sleep during the count aborts the handover, so `xtal_active` stays 0.
- R10: A `wake_evt` in sleep restarts the two-speed sequence. The internal clock runs at once, and the handover waits for a full new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC clock, always running; domain of the control logic |
| clk_xtal | input | 1 | External crystal/resonator or external clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrup_ok | input | 1 | Power-up delay has expired (synchronous to clk_rc) |
| sleep_req | input | 1 | Enter sleep (synchronous to clk_rc) |
| wake_evt | input | 1 | Leave sleep (synchronous to clk_rc) |
| osc_cfg | input | 3 | Oscillator mode: 0..2 crystal, 3 direct external, 4..7 internal |
| dual_start_en | input | 1 | Run from the internal clock while the count proceeds |
| clksel_we | input | 1 | Write strobe for the software select bit |
| clksel_wdata | input | 1 | Value written to the software select bit (1 = internal clock) |
| sys_clk | output | 1 | Gated system clock |
| xtal_active | output | 1 | Status: system clock committed to the external source |

## Verification
On every internal clock cycle, the assertions check the following. The two clock gates are never open together. The status bit never rises unless the count has completed or the mode is the direct external clock. The internal gate stays shut before power-up and during sleep. The software select changes only on a write. A wake always starts from a cleared count. Some properties need wall-clock time and can only be shown by the bench scenarios: the edge rate of `sys_clk` in each of the 32 configurations before and after the handover, the delay from power-up or wake to the status bit measured against the count length, the aborted handover, and the narrowest pulse seen on `sys_clk` over the whole run.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;

  localparam logic [2:0] CFG_LAST_XTAL = 3'd2;
  localparam logic [2:0] CFG_EXT_CLK   = 3'd3;

  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_RUN   = 2'd1,
    PH_SLEEP = 2'd2
  } phase_e;

  // crystal/resonator modes need the settling count
  function automatic logic needs_count(input logic [2:0] cfg);
    return cfg <= CFG_LAST_XTAL;
  endfunction

  function automatic logic ext_direct(input logic [2:0] cfg);
    return cfg == CFG_EXT_CLK;
  endfunction

  function automatic logic rc_only(input logic [2:0] cfg);
    return cfg[2];
  endfunction

  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tsc_sync.sv
`timescale 1ns/1ps
module tsc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsc_startup_timer.sv
`timescale 1ns/1ps
module tsc_startup_timer #(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = tsc_pkg::count_width(OST_CYCLES)
) (
  input  logic          clk_xtal,
  input  logic          rst_n,
  input  logic          run_req,
  output logic          run_x,
  output logic          done_x,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LIMIT = CW'(OST_CYCLES);

  tsc_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk_xtal), .rst_n(rst_n), .d(run_req), .q(run_x)
  );

  logic reached;
  assign reached = (count == LIMIT);

  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      done_x <= 1'b0;
    end else if (!run_x) begin
      count  <= '0;
      done_x <= 1'b0;
    end else begin
      if (!reached) count <= count + CW'(1);
      done_x <= reached;
    end
  end
endmodule

// File: rtl/tsc_ctrl.sv
`timescale 1ns/1ps
module tsc_ctrl (
  input  logic       clk_rc,
  input  logic       rst_n,
  input  logic       pwrup_ok,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic [2:0] osc_cfg,
  input  logic       dual_start_en,
  input  logic       clksel_we,
  input  logic       clksel_wdata,
  input  logic       done_r,
  input  logic       run_ack_r,
  output logic       want_rc,
  output logic       want_xtal,
  output logic       count_run,
  output logic       clksel,
  output logic       in_pwrup,
  output logic       in_run,
  output logic       in_sleep,
  output logic       ost_ok
);
  import tsc_pkg::*;

  phase_e phase_q, phase_n;
  logic   wake_pend_q, wake_seen, sel_n, run_n, ext_n, rc_n, cnt_n;

  assign wake_seen = wake_evt | wake_pend_q;

  always_comb begin
    phase_n = phase_q;
    case (phase_q)
      PH_PWRUP: if (pwrup_ok)  phase_n = PH_RUN;
      PH_RUN:   if (sleep_req) phase_n = PH_SLEEP;
      // leave sleep only once the timer side has seen the count cleared
      PH_SLEEP: if (wake_seen && !done_r && !run_ack_r) phase_n = PH_RUN;
      default:  phase_n = PH_PWRUP;
    endcase
  end

  assign sel_n = clksel_we ? clksel_wdata : clksel;
  assign run_n = (phase_n == PH_RUN);
  assign cnt_n = run_n & needs_count(osc_cfg);
  assign ext_n = run_n & ~sel_n &
                 (ext_direct(osc_cfg) | (needs_count(osc_cfg) & done_r));
  assign rc_n  = run_n & ~ext_n &
                 (sel_n | rc_only(osc_cfg) | (needs_count(osc_cfg) & dual_start_en));

  always_ff @(posedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_PWRUP;
      wake_pend_q <= 1'b0;
      clksel      <= 1'b0;
      want_rc     <= 1'b0;
      want_xtal   <= 1'b0;
      count_run   <= 1'b0;
    end else begin
      phase_q     <= phase_n;
      wake_pend_q <= (phase_q == PH_SLEEP) && (phase_n == PH_SLEEP) && wake_seen;
      clksel      <= sel_n;
      want_rc     <= rc_n;
      want_xtal   <= ext_n;
      count_run   <= cnt_n;
    end
  end

  assign in_pwrup = (phase_q == PH_PWRUP);
  assign in_run   = (phase_q == PH_RUN);
  assign in_sleep = (phase_q == PH_SLEEP);
  assign ost_ok   = in_run & done_r;
endmodule

// File: rtl/tsc_glitchless_mux.sv
`timescale 1ns/1ps
module tsc_glitchless_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_rc,
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic want_rc,
  input  logic want_xtal,
  output logic gate_rc,
  output logic gate_xtal,
  output logic xtal_commit,
  output logic sys_clk
);
  logic xtal_on_r, commit_x, commit_n;

  tsc_sync #(.STAGES(SYNC_STAGES)) u_xon_sync (
    .clk(clk_rc), .rst_n(rst_n), .d(gate_xtal), .q(xtal_on_r)
  );

  // commitment holds until the external side has acknowledged it
  assign commit_n = want_xtal | (xtal_commit & ~xtal_on_r);

  always_ff @(negedge clk_rc or negedge rst_n) begin
    if (!rst_n) begin
      gate_rc     <= 1'b0;
      xtal_commit <= 1'b0;
    end else begin
      gate_rc     <= want_rc & ~commit_n & ~xtal_on_r;
      xtal_commit <= commit_n;
    end
  end

  tsc_sync #(.STAGES(SYNC_STAGES)) u_commit_sync (
    .clk(clk_xtal), .rst_n(rst_n), .d(xtal_commit), .q(commit_x)
  );

  always_ff @(negedge clk_xtal or negedge rst_n) begin
    if (!rst_n) gate_xtal <= 1'b0;
    else        gate_xtal <= commit_x;
  end

  assign sys_clk = (clk_rc & gate_rc) | (clk_xtal & gate_xtal);
endmodule

// File: rtl/twospeed_clk_ctrl.sv
`timescale 1ns/1ps
module twospeed_clk_ctrl #(
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_rc,
  input  logic       clk_xtal,
  input  logic       rst_n,
  input  logic       pwrup_ok,
  input  logic       sleep_req,
  input  logic       wake_evt,
  input  logic [2:0] osc_cfg,
  input  logic       dual_start_en,
  input  logic       clksel_we,
  input  logic       clksel_wdata,
  output logic       sys_clk,
  output logic       xtal_active
);
  localparam int unsigned CW = tsc_pkg::count_width(OST_CYCLES);

  logic          count_run, run_x, done_x, done_r, run_ack_r;
  logic          want_rc, want_xtal, clksel;
  logic          in_pwrup, in_run, in_sleep, ost_ok;
  logic          gate_rc, gate_xtal, xtal_commit;
  logic [CW-1:0] tmr_count;

  tsc_startup_timer #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk_xtal(clk_xtal), .rst_n(rst_n), .run_req(count_run),
    .run_x(run_x), .done_x(done_x), .count(tmr_count)
  );

  tsc_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk_rc), .rst_n(rst_n), .d(done_x), .q(done_r)
  );

  tsc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_rc), .rst_n(rst_n), .d(run_x), .q(run_ack_r)
  );

  tsc_ctrl u_ctrl (
    .clk_rc(clk_rc), .rst_n(rst_n), .pwrup_ok(pwrup_ok),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .osc_cfg(osc_cfg),
    .dual_start_en(dual_start_en), .clksel_we(clksel_we),
    .clksel_wdata(clksel_wdata), .done_r(done_r), .run_ack_r(run_ack_r),
    .want_rc(want_rc), .want_xtal(want_xtal), .count_run(count_run),
    .clksel(clksel), .in_pwrup(in_pwrup), .in_run(in_run),
    .in_sleep(in_sleep), .ost_ok(ost_ok)
  );

  tsc_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_rc(clk_rc), .clk_xtal(clk_xtal), .rst_n(rst_n),
    .want_rc(want_rc), .want_xtal(want_xtal),
    .gate_rc(gate_rc), .gate_xtal(gate_xtal),
    .xtal_commit(xtal_commit), .sys_clk(sys_clk)
  );

  assign xtal_active = xtal_commit;
endmodule

// File: rtl/tsc_checker.sv
`timescale 1ns/1ps
module tsc_checker #(
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned CW = 11
) (
  input logic          clk_rc,
  input logic          clk_xtal,
  input logic          rst_n,
  input logic [2:0]    osc_cfg,
  input logic          clksel_we,
  input logic          clksel,
  input logic          in_pwrup,
  input logic          in_run,
  input logic          in_sleep,
  input logic          ost_ok,
  input logic          done_r,
  input logic          gate_rc,
  input logic          gate_xtal,
  input logic          xtal_active,
  input logic [CW-1:0] tmr_count
);
  p_gates_exclusive_r4: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !(gate_rc && gate_xtal));

  p_status_needs_count_r3: assert property (@(posedge clk_rc) disable iff (!rst_n)
    $rose(xtal_active) |-> (osc_cfg == 3'd3) || $past(ost_ok));

  p_pwrup_quiet_r1: assert property (@(posedge clk_rc) disable iff (!rst_n)
    in_pwrup |-> !gate_rc && !gate_xtal && !xtal_active);

  p_sleep_quiet_r9: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (in_sleep && $past(in_sleep)) |-> !gate_rc);

  p_sel_sw_only_r8: assert property (@(posedge clk_rc) disable iff (!rst_n)
    !clksel_we |=> $stable(clksel));

  p_wake_fresh_r10: assert property (@(posedge clk_rc) disable iff (!rst_n)
    (in_run && $past(in_sleep)) |-> !done_r);

  p_count_bounded_r3: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    tmr_count <= CW'(OST_CYCLES));
endmodule

bind twospeed_clk_ctrl tsc_checker #(.OST_CYCLES(OST_CYCLES), .CW(CW)) i_checker (
  .clk_rc(clk_rc), .clk_xtal(clk_xtal), .rst_n(rst_n), .osc_cfg(osc_cfg),
  .clksel_we(clksel_we), .clksel(clksel), .in_pwrup(in_pwrup),
  .in_run(in_run), .in_sleep(in_sleep), .ost_ok(ost_ok), .done_r(done_r),
  .gate_rc(gate_rc), .gate_xtal(gate_xtal), .xtal_active(xtal_active),
  .tmr_count(tmr_count)
);

// File: tb/test_twospeed_clk_ctrl.sv
`timescale 1ns/1ps
module test_twospeed_clk_ctrl;
  localparam int  OSTN  = 128;
  localparam real TXTAL = 26.0;
  localparam int  SRC_LOW = 0, SRC_RC = 1, SRC_XTAL = 2, SRC_MIX = 3;

  logic clk_rc = 1'b0, clk_xtal = 1'b0;
  logic rst_n = 1'b0, pwrup_ok = 1'b0, sleep_req = 1'b0, wake_evt = 1'b0;
  logic [2:0] osc_cfg = 3'd0;
  logic dual_start_en = 1'b0, clksel_we = 1'b0, clksel_wdata = 1'b0;
  logic sys_clk, xtal_active;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk_rc = ~clk_rc;
  initial begin
    #3;
    forever #13 clk_xtal = ~clk_xtal;
  end

  twospeed_clk_ctrl #(.OST_CYCLES(OSTN)) i_twospeed_clk_ctrl (
    .clk_rc(clk_rc), .clk_xtal(clk_xtal), .rst_n(rst_n), .pwrup_ok(pwrup_ok),
    .sleep_req(sleep_req), .wake_evt(wake_evt), .osc_cfg(osc_cfg),
    .dual_start_en(dual_start_en), .clksel_we(clksel_we),
    .clksel_wdata(clksel_wdata), .sys_clk(sys_clk), .xtal_active(xtal_active)
  );

  int unsigned edges = 0;
  always @(posedge sys_clk) edges++;

  realtime last_edge = 0.0, min_pw = 1000.0;
  always @(sys_clk or negedge rst_n) begin
    if (!rst_n) last_edge = 0.0;
    else begin
      if (last_edge > 0.0 && ($realtime - last_edge) < min_pw) min_pw = $realtime - last_edge;
      last_edge = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int classify(input int n);
    if (n == 0) return SRC_LOW;
    if (n >= 180 && n <= 210) return SRC_RC;
    if (n >= 65 && n <= 90) return SRC_XTAL;
    return SRC_MIX;
  endfunction

  task automatic measure(output int src);
    int unsigned n0;
    n0 = edges;
    #2000;
    src = classify(int'(edges - n0));
  endtask

  task automatic do_reset();
    @(negedge clk_rc);
    rst_n = 1'b0; pwrup_ok = 1'b0; sleep_req = 1'b0; wake_evt = 1'b0; clksel_we = 1'b0;
    repeat (3) @(negedge clk_rc);
    rst_n = 1'b1;
    @(negedge clk_rc);
  endtask

  task automatic write_sel(input bit v);
    @(negedge clk_rc); clksel_we = 1'b1; clksel_wdata = v;
    @(negedge clk_rc); clksel_we = 1'b0;
  endtask

  task automatic pulse_sleep();
    @(negedge clk_rc); sleep_req = 1'b1;
    @(negedge clk_rc); sleep_req = 1'b0;
  endtask

  task automatic wake_up(output realtime t0);
    @(negedge clk_rc); wake_evt = 1'b1; t0 = $realtime;
    @(negedge clk_rc); wake_evt = 1'b0;
  endtask

  task automatic power_up(output realtime t0);
    @(negedge clk_rc); pwrup_ok = 1'b1; t0 = $realtime;
  endtask

  task automatic wait_status(output realtime t);
    for (int i = 0; i < 4000; i++) begin
      if (xtal_active) break;
      #2;
    end
    t = $realtime;
  endtask

  function automatic int exp_first(input int cfg, input bit en, input bit sel);
    if (sel || cfg >= 4) return SRC_RC;
    if (cfg == 3) return SRC_XTAL;
    return en ? SRC_RC : SRC_LOW;
  endfunction

  function automatic int exp_last(input int cfg, input bit sel);
    if (sel || cfg >= 4) return SRC_RC;
    return SRC_XTAL;
  endfunction

  function automatic string tag_for(input int cfg, input bit en, input bit sel);
    if (sel) return "R7";
    if (cfg >= 3) return "R6";
    return en ? "R2" : "R5";
  endfunction

  initial begin
    int src;
    realtime t0, t1, tmin, tmax;
    tmin = OSTN * TXTAL;
    tmax = OSTN * TXTAL + 400.0;

    // R1: before power-up completes
    osc_cfg = 3'd0; dual_start_en = 1'b1;
    do_reset();
    check(xtal_active == 1'b0, "R1", "status after reset", xtal_active, 0);
    measure(src);
    check(src == SRC_LOW, "R1", "source before pwrup", src, SRC_LOW);
    check(xtal_active == 1'b0, "R1", "status before pwrup", xtal_active, 0);

    // R2, R3, R4: two-speed start in crystal mode
    power_up(t0);
    #200;
    measure(src);
    check(src == SRC_RC, "R2", "source during count", src, SRC_RC);
    check(xtal_active == 1'b0, "R2", "status during count", xtal_active, 0);
    wait_status(t1);
    check((t1 - t0) >= tmin, "R3", "count too short ns", int'(t1 - t0), int'(tmin));
    check((t1 - t0) <= tmax, "R3", "count too long ns", int'(t1 - t0), int'(tmax));
    #300;
    measure(src);
    check(src == SRC_XTAL, "R4", "source after handover", src, SRC_XTAL);
    // R8: handover left the software select at 0 (external clock still chosen)
    check(src == SRC_XTAL, "R8", "select untouched by handover", src, SRC_XTAL);

    // R7: live software select
    write_sel(1'b1);
    #300;
    measure(src);
    check(src == SRC_RC, "R7", "select=1 source", src, SRC_RC);
    check(xtal_active == 1'b0, "R7", "select=1 status", xtal_active, 0);
    write_sel(1'b0);
    #300;
    measure(src);
    check(src == SRC_XTAL, "R7", "select back to 0 source", src, SRC_XTAL);
    check(xtal_active == 1'b1, "R7", "select back to 0 status", xtal_active, 1);

    // R8: reset clears the select
    osc_cfg = 3'd3;
    write_sel(1'b1);
    do_reset();
    power_up(t0);
    #200;
    measure(src);
    check(src == SRC_XTAL, "R8", "select cleared by reset", src, SRC_XTAL);

    // R2, R5, R6, R7: sweep of all configurations
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int en = 0; en < 2; en++) begin
        for (int sel = 0; sel < 2; sel++) begin
          osc_cfg = 3'(cfg); dual_start_en = en[0];
          do_reset();
          if (sel != 0) write_sel(1'b1);
          power_up(t0);
          #200;
          measure(src);
          check(src == exp_first(cfg, en[0], sel[0]), tag_for(cfg, en[0], sel[0]),
                $sformatf("cfg%0d en%0d sel%0d first source", cfg, en, sel),
                src, exp_first(cfg, en[0], sel[0]));
          check(xtal_active == (cfg == 3 && sel == 0), tag_for(cfg, en[0], sel[0]),
                $sformatf("cfg%0d en%0d sel%0d first status", cfg, en, sel),
                xtal_active, int'(cfg == 3 && sel == 0));
          #2200;
          measure(src);
          check(src == exp_last(cfg, sel[0]), tag_for(cfg, en[0], sel[0]),
                $sformatf("cfg%0d en%0d sel%0d last source", cfg, en, sel),
                src, exp_last(cfg, sel[0]));
          check(xtal_active == (cfg < 4 && sel == 0), tag_for(cfg, en[0], sel[0]),
                $sformatf("cfg%0d en%0d sel%0d last status", cfg, en, sel),
                xtal_active, int'(cfg < 4 && sel == 0));
        end
      end
    end

    // R9: sleep during the count aborts the handover
    osc_cfg = 3'd1; dual_start_en = 1'b1;
    do_reset();
    power_up(t0);
    #1000;
    pulse_sleep();
    #200;
    measure(src);
    check(src == SRC_LOW, "R9", "asleep source", src, SRC_LOW);
    #3000;
    measure(src);
    check(src == SRC_LOW, "R9", "aborted count source", src, SRC_LOW);
    check(xtal_active == 1'b0, "R9", "aborted count status", xtal_active, 0);

    // R10: wake restarts with a full count
    wake_up(t0);
    #200;
    measure(src);
    check(src == SRC_RC, "R10", "source after wake", src, SRC_RC);
    check(xtal_active == 1'b0, "R10", "status after wake", xtal_active, 0);
    wait_status(t1);
    check((t1 - t0) >= tmin, "R10", "fresh count too short ns", int'(t1 - t0), int'(tmin));
    check((t1 - t0) <= tmax, "R10", "fresh count too long ns", int'(t1 - t0), int'(tmax));
    #300;
    measure(src);
    check(src == SRC_XTAL, "R10", "source after second handover", src, SRC_XTAL);

    // R9: sleep while on the external clock
    pulse_sleep();
    #300;
    measure(src);
    check(src == SRC_LOW, "R9", "sleep from external source", src, SRC_LOW);
    check(xtal_active == 1'b0, "R9", "sleep from external status", xtal_active, 0);
    wake_up(t0);
    #200;
    measure(src);
    check(src == SRC_RC, "R10", "wake from external sleep", src, SRC_RC);

    // R4: no runt pulse seen anywhere in the run
    check(min_pw >= 4.9, "R4", "narrowest pulse ps", int'(min_pw * 1000.0), 5000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule